// File: doc/BRIEF.md
# Memory Power-Up and Sleep Sequencer

This block sits between a memory bus controller and a non-volatile asynchronous memory. It keeps the memory's chip-enable and write-enable lines forced inactive (high) and reports the memory as not usable until it may be accessed. Supply status arrives as two digital inputs: a power-good level and a brownout level that means the supply is below the write-inhibit threshold. Whenever the supply becomes good, the sequencer enforces a startup hold of a parameterised number of clock cycles. A brownout at any time aborts whatever is in progress and re-arms the full hold.

The host can also put the memory into its deep-sleep/reset mode with a level request. The sequencer waits for any bus cycle in flight to end, drives the sleep pin high for at least a minimum number of cycles, and keeps it high while the request stays asserted. When the request drops, it releases the pin only while the enable overrides are already in force. It then holds off all accesses for a post-exit initialisation wait. All delays are counted in clock cycles, so the parameters are set from the clock period.

Top module: `mram_pwr_seq`

## Requirements
- R1: While power-good is low, from the next clock edge on the outputs are sleep pin low, force-high override high and ready low.
- R2: Once power-good is high and brownout is low, ready rises on the STARTUP_CYC-th clock edge after the first edge that samples the good supply, and stays low before that.
- R3: A brownout sampled on any edge forces the startup hold on that edge (ready low, override high, sleep pin low), and the full STARTUP_CYC hold starts again once the supply is good.
- R4: The force-high override is low only in the operational state; in every other state, including whenever the sleep pin is high, it is high.
- R5: A sleep request in the operational state raises the sleep pin on the first edge that samples the request with bus-busy low; while bus-busy is high the pin stays low.
- R6: Ready is low in the operational state while a sleep request is pending.
- R7: Once raised, the sleep pin stays high for at least SLEEP_MIN_CYC cycles even if the request is withdrawn, unless the supply fails.
- R8: The sleep pin falls only in a cycle where the force-high override was already high in the cycle before.
- R9: After the sleep pin falls on exit, ready stays low for EXIT_WAIT_CYC cycles and then rises.
- R10: While asleep, the sleep pin stays high for as long as the request is held, and bus-busy has no effect.
- R11: A synchronous active-low reset puts the block into the power-off state (sleep pin low, override high, ready low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good_i | input | 1 | Supply at or above the minimum operating level |
| brownout_i | input | 1 | Supply below the write-inhibit threshold |
| sleep_req_i | input | 1 | Level request: high to sleep, low to wake |
| bus_busy_i | input | 1 | A memory bus cycle is in progress |
| zz_o | output | 1 | Sleep/reset pin level for the memory |
| force_ctl_hi_o | output | 1 | Forces chip-enable and write-enable lines high |
| ready_o | output | 1 | Memory may be accessed |

## Verification
On every cycle the assertions check that the sleep pin never sits high without the override, that it falls only while the override was already in force, that it stays high for the minimum count unless the supply fails, and that a lost supply or a brownout removes ready on the next edge. The exact cycle lengths of the startup hold and the exit wait, the deferral of sleep behind a busy bus, the re-arming after a brownout and the effect of reset can only be shown by the bench's scripted sequences.

// File: rtl/mram_pwr_seq_pkg.sv
// Shared definitions for the memory power sequencer: one-hot state indices.
// Assumes every state vector in the block is NST bits wide with exactly one bit set.
package mram_pwr_seq_pkg;
    localparam int NST       = 6;
    localparam int S_OFF     = 0;  // supply not good
    localparam int S_START   = 1;  // startup hold counting
    localparam int S_RDY     = 2;  // operational, accesses allowed
    localparam int S_SENTER  = 3;  // sleep pin high, minimum width counting
    localparam int S_SLEEP   = 4;  // asleep until request drops
    localparam int S_EXIT    = 5;  // post-exit initialisation wait
    localparam logic [NST-1:0] ST_OFF_VEC = NST'(1) << S_OFF;
endpackage

// File: rtl/mram_seq_timer.sv
// Shared down-counter for all timed states.
// Loads LOAD value on load_i, then decrements to zero and holds; done_o is high at zero.
// Assumes the caller loads (value - 1) so that a state lasts exactly value cycles.
module mram_seq_timer #(
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          done_o
);
    logic [CW-1:0] cnt;

    // Count register: load on state entry, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load_i)
            cnt <= load_val_i;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done_o = (cnt == '0);
endmodule

// File: rtl/mram_seq_fsm.sv
// One-hot control state machine of the power sequencer.
// Supply loss has priority over every transition. Requests timer loads on state entry.
// Assumes tmr_done_i reflects the count loaded when the current state was entered.
module mram_seq_fsm
    import mram_pwr_seq_pkg::*;
#(
    parameter int STARTUP_CYC   = 100000,
    parameter int SLEEP_MIN_CYC = 2,
    parameter int EXIT_WAIT_CYC = 5000,
    parameter int CW            = 17
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           supply_ok_i,
    input  logic           sleep_req_i,
    input  logic           bus_busy_i,
    input  logic           tmr_done_i,
    output logic [NST-1:0] st_o,
    output logic           load_o,
    output logic [CW-1:0]  load_val_o
);
    logic [NST-1:0] st, nxt;

    // Next-state decode; supply loss overrides everything.
    always_comb begin
        nxt = '0;
        if (!supply_ok_i) begin
            nxt[S_OFF] = 1'b1;
        end else begin
            unique case (1'b1)
                st[S_OFF]:    nxt[S_START] = 1'b1;
                st[S_START]:  if (tmr_done_i) nxt[S_RDY] = 1'b1;
                              else            nxt[S_START] = 1'b1;
                st[S_RDY]:    if (sleep_req_i && !bus_busy_i) nxt[S_SENTER] = 1'b1;
                              else                            nxt[S_RDY]    = 1'b1;
                st[S_SENTER]: if (tmr_done_i) nxt[S_SLEEP] = 1'b1;
                              else            nxt[S_SENTER] = 1'b1;
                st[S_SLEEP]:  if (!sleep_req_i) nxt[S_EXIT]  = 1'b1;
                              else              nxt[S_SLEEP] = 1'b1;
                st[S_EXIT]:   if (tmr_done_i) nxt[S_RDY]  = 1'b1;
                              else            nxt[S_EXIT] = 1'b1;
                default:      nxt[S_OFF] = 1'b1;
            endcase
        end
    end

    // Timer load request and value for the state being entered.
    always_comb begin
        load_o = (nxt != st);
        if (nxt[S_START])
            load_val_o = CW'(STARTUP_CYC - 1);
        else if (nxt[S_SENTER])
            load_val_o = CW'(SLEEP_MIN_CYC - 1);
        else if (nxt[S_EXIT])
            load_val_o = CW'(EXIT_WAIT_CYC - 1);
        else
            load_val_o = '0;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_OFF_VEC;
        else
            st <= nxt;
    end

    assign st_o = st;
endmodule

// File: rtl/mram_pwr_seq.sv
// Top of the memory power-up and sleep/reset sequencer.
// Combines the two supply inputs, runs the state machine and a shared timer,
// and decodes the sleep pin, the enable override and ready from the state.
// Assumes supply inputs are already synchronous to clk; all delays >= 1 cycle.
module mram_pwr_seq
    import mram_pwr_seq_pkg::*;
#(
    parameter int STARTUP_CYC   = 100000,
    parameter int SLEEP_MIN_CYC = 2,
    parameter int EXIT_WAIT_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good_i,
    input  logic brownout_i,
    input  logic sleep_req_i,
    input  logic bus_busy_i,
    output logic zz_o,
    output logic force_ctl_hi_o,
    output logic ready_o
);
    localparam int MAXC = (STARTUP_CYC > EXIT_WAIT_CYC)
                        ? ((STARTUP_CYC > SLEEP_MIN_CYC) ? STARTUP_CYC : SLEEP_MIN_CYC)
                        : ((EXIT_WAIT_CYC > SLEEP_MIN_CYC) ? EXIT_WAIT_CYC : SLEEP_MIN_CYC);
    localparam int CW   = $clog2(MAXC + 1);

    logic           supply_ok;
    logic [NST-1:0] st;
    logic           tmr_load, tmr_done;
    logic [CW-1:0]  tmr_val;

    assign supply_ok = pwr_good_i & ~brownout_i;

    mram_seq_fsm #(
        .STARTUP_CYC  (STARTUP_CYC),
        .SLEEP_MIN_CYC(SLEEP_MIN_CYC),
        .EXIT_WAIT_CYC(EXIT_WAIT_CYC),
        .CW           (CW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_ok_i(supply_ok),
        .sleep_req_i(sleep_req_i),
        .bus_busy_i (bus_busy_i),
        .tmr_done_i (tmr_done),
        .st_o       (st),
        .load_o     (tmr_load),
        .load_val_o (tmr_val)
    );

    mram_seq_timer #(.CW(CW)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .done_o    (tmr_done)
    );

    // Output decode from the registered one-hot state.
    always_comb begin
        zz_o           = st[S_SENTER] | st[S_SLEEP];
        force_ctl_hi_o = ~st[S_RDY];
        ready_o        = st[S_RDY] & ~sleep_req_i;
    end
endmodule

// File: rtl/mram_pwr_seq_chk.sv
// Assertion checker for the power sequencer, attached to every instance by bind.
// Observes ports only; counts sleep-pin high time for the minimum-width check.
module mram_pwr_seq_chk #(
    parameter int SLEEP_MIN_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_good_i,
    input logic brownout_i,
    input logic zz_o,
    input logic force_ctl_hi_o,
    input logic ready_o
);
    logic [31:0] hi_cnt;

    // Consecutive cycles the sleep pin has been high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_cnt <= '0;
        else if (!zz_o)
            hi_cnt <= '0;
        else if (hi_cnt < 32'(SLEEP_MIN_CYC))
            hi_cnt <= hi_cnt + 1'b1;
    end

    a_r1_no_supply_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good_i |=> (!ready_o && force_ctl_hi_o && !zz_o));

    a_r3_brownout_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $past(brownout_i) |-> !ready_o);

    a_r4_override_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        zz_o |-> force_ctl_hi_o);

    a_r7_min_sleep_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(zz_o) && $past(pwr_good_i) && !$past(brownout_i))
            |-> (hi_cnt >= 32'(SLEEP_MIN_CYC)));

    a_r8_exit_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(zz_o) |-> (force_ctl_hi_o && $past(force_ctl_hi_o)));
endmodule

bind mram_pwr_seq mram_pwr_seq_chk #(.SLEEP_MIN_CYC(SLEEP_MIN_CYC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_good_i    (pwr_good_i),
    .brownout_i    (brownout_i),
    .zz_o          (zz_o),
    .force_ctl_hi_o(force_ctl_hi_o),
    .ready_o       (ready_o)
);

// File: tb/mram_pwr_seq_tb_top.sv
// Bench: vector table walked by one loop, then directed reset tests.
module mram_pwr_seq_tb_top;
    localparam int ST_C = 20;
    localparam int MN_C = 3;
    localparam int EX_C = 10;
    localparam int NV   = 17;

    logic clk = 1'b0;
    logic rst_n, pg, bo, sr, bz;
    logic zz, frc, rdy;
    int   checks = 0;
    int   fails  = 0;
    bit   fin    = 1'b0;

    always #10 clk = ~clk;

    mram_pwr_seq #(
        .STARTUP_CYC  (ST_C),
        .SLEEP_MIN_CYC(MN_C),
        .EXIT_WAIT_CYC(EX_C)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_good_i(pg), .brownout_i(bo),
        .sleep_req_i(sr), .bus_busy_i(bz),
        .zz_o(zz), .force_ctl_hi_o(frc), .ready_o(rdy)
    );

    // fields: pg, bo, sr, bz, ticks[7:0], exp zz, exp force, exp ready, req[3:0]
    localparam logic [18:0] VEC [NV] = '{
        {4'b0000, 8'd3,  3'b010, 4'd1},   // R1 no supply
        {4'b1000, 8'd20, 3'b010, 4'd2},   // R2 still in hold
        {4'b1000, 8'd1,  3'b001, 4'd2},   // R2 ready on exact edge
        {4'b1100, 8'd1,  3'b010, 4'd3},   // R3 brownout drops ready
        {4'b1000, 8'd20, 3'b010, 4'd3},   // R3 full hold re-armed
        {4'b1000, 8'd1,  3'b001, 4'd4},   // R4 override low when operational
        {4'b1011, 8'd4,  3'b000, 4'd6},   // R6, R5 request waits on busy
        {4'b1010, 8'd1,  3'b110, 4'd5},   // R5 enters sleep when bus idle
        {4'b1000, 8'd3,  3'b110, 4'd7},   // R7 minimum width despite withdrawal
        {4'b1000, 8'd1,  3'b010, 4'd8},   // R8 pin falls under override
        {4'b1000, 8'd9,  3'b010, 4'd9},   // R9 exit wait
        {4'b1000, 8'd1,  3'b001, 4'd9},   // R9 ready after exit wait
        {4'b1010, 8'd1,  3'b110, 4'd5},   // R5 immediate entry
        {4'b1011, 8'd10, 3'b110, 4'd10},  // R10 held asleep, busy ignored
        {4'b1110, 8'd1,  3'b010, 4'd3},   // R3 brownout while asleep
        {4'b1000, 8'd21, 3'b001, 4'd2},   // R2 recovery
        {4'b0000, 8'd1,  3'b010, 4'd1}    // R1 supply loss from operational
    };

    // Advance one clock and settle away from the edge.
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #5;
        end
    endtask

    // Compare outputs against expectations for requirement number rq.
    task automatic check(input int rq, input logic ez, input logic ef, input logic er);
        checks++;
        if (zz !== ez || frc !== ef || rdy !== er) begin
            fails++;
            $display("FAIL R%0d: zz/force/ready actual %b%b%b expected %b%b%b",
                     rq, zz, frc, rdy, ez, ef, er);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!fin) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pg = 1'b1; bo = 1'b0; sr = 1'b0; bz = 1'b0;
        tick(3);
        check(11, 1'b0, 1'b1, 1'b0);   // R11 reset state
        rst_n = 1'b1; pg = 1'b0;
        for (int v = 0; v < NV; v++) begin
            {pg, bo, sr, bz} = VEC[v][18:15];
            tick(int'(VEC[v][14:7]));
            check(int'(VEC[v][3:0]), VEC[v][6], VEC[v][5], VEC[v][4]);
        end
        // R11: reset from the operational state
        pg = 1'b1; bo = 1'b0; sr = 1'b0; bz = 1'b0;
        tick(ST_C + 1);
        check(2, 1'b0, 1'b0, 1'b1);
        rst_n = 1'b0;
        tick(1);
        check(11, 1'b0, 1'b1, 1'b0);
        rst_n = 1'b1;
        tick(ST_C);
        check(11, 1'b0, 1'b1, 1'b0);   // R11 full hold after reset
        tick(1);
        check(11, 1'b0, 1'b0, 1'b1);
        // R3: brownout during exit wait re-arms the hold
        sr = 1'b1; tick(MN_C + 1);
        sr = 1'b0; tick(3);
        check(9, 1'b0, 1'b1, 1'b0);
        bo = 1'b1; tick(1);
        bo = 1'b0; tick(ST_C);
        check(3, 1'b0, 1'b1, 1'b0);
        tick(1);
        check(3, 1'b0, 1'b0, 1'b1);
        fin = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule